// File: doc/BRIEF.md
# Vertical format paper-motion sequencer

This block carries out paper-motion requests for a line printer whose vertical format is held in a small memory outside the block. Each memory entry is a word of channel-stop bits, and bit 0 of an entry marks the top-of-form line. A request either slews the paper a given number of lines or searches forward for the next line whose entry has the stop bit of a chosen channel. The block keeps the format length, the format pointer and a 12-bit page counter. It drives line-feed and form-feed strobes to the printer through a valid/ready handshake.

At the end of each request the block pulses `done` and presents `halt`. When `halt` is low, printing may go on. When it is high, either the page counter has run down to zero or the channel search found no stop and the format has been declared invalid. The memory is read through a combinational read port. Loading the memory contents and translating characters belong to other blocks.

Top module: `vfu_motion`

## Requirements
- R1: A slew request (`req_kind`=0) with a nonzero count N emits exactly N line feeds. Each accepted line feed pulses `col_clr`. The pointer ends at (start + N) mod length, or at 0 when the length is 0.
- R2: A slew request with count 0 emits no feed. It completes with `done` and `halt`=0, and leaves the pointer and the page counter unchanged.
- R3: After a slew, and after a nonzero-channel hit, the block checks bit 0 of the entry at the pointer. If that bit is set, the page counter decrements modulo 4096. If the result is zero, `page_zero` is set and `halt` is 1. Otherwise `page_zero` is cleared and `halt` is 0. If the bit is clear, the page counter and `page_zero` stay as they were.
- R4: In a search request (`req_kind`=1), a channel argument above 11 selects channel 7.
- R5: A search advances the pointer one entry at a time and wraps to 0 at the length. It tests the channel bit of each entry it reaches and stops at the first one set. On a hit for a nonzero channel after k steps, the block emits k line feeds and leaves the pointer on the hit entry.
- R6: On a hit for channel 0, the block first emits one line feed if `col_nz` is 1. It then emits one form feed (`feed_ff`=1) and decrements the page counter under the zero rule of R3.
- R7: If a search finds no set bit within `fmt_len` steps, or the length is 0, the length becomes 0 and `halt` is 1. The pointer ends where it started.
- R8: While `feed_valid` is high and `feed_ready` is low, `feed_valid` and `feed_ff` hold. One feed is consumed per cycle in which both are high.
- R9: `req_ready` is high only when the block is idle and no load is being presented. Every accepted request yields a `done` pulse exactly one cycle long, with no feed pending.
- R10: The block takes a length or page-counter load only while idle. Loads presented during a request have no effect. A length load returns the pointer to 0 and does not change `page_zero`.
- R11: After reset the block is idle and shows length 0, pointer 0, page count 0, `page_zero` low and no feed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_kind | input | 1 | 0 = slew lines, 1 = channel search |
| req_arg | input | 4 | Slew count or channel number |
| fmt_len_load | input | 1 | Load the format length (idle only) |
| fmt_len_val | input | 8 | Length value to load |
| page_load | input | 1 | Load the page counter (idle only) |
| page_val | input | 12 | Page counter value to load |
| col_nz | input | 1 | Current print column is nonzero |
| mem_addr | output | 8 | Format memory read address |
| mem_data | input | 12 | Format memory entry, channel bits, bit 0 = top of form |
| feed_valid | output | 1 | Feed strobe pending |
| feed_ready | input | 1 | Printer takes the feed |
| feed_ff | output | 1 | 1 = form feed, 0 = line feed |
| col_clr | output | 1 | Column reset, pulses on each accepted line feed |
| done | output | 1 | One-cycle end-of-request pulse |
| halt | output | 1 | Printing must stop (valid with `done`) |
| page_zero | output | 1 | Page counter reached zero on its last decrement |
| page_cnt | output | 12 | Page counter |
| fmt_len | output | 8 | Current format length |
| fmt_ptr | output | 8 | Current format pointer |

## Verification
Several properties are checked on every cycle. These are the feed hold under back-pressure, quiet outputs while idle, the single-cycle `done`, the pointer staying below a nonzero length, the rule that the page counter only moves by a load or a decrement of one, a halt without page zero implying an invalidated format, and a form feed always decrementing the page. Other behaviour can only be shown by the bench scenarios against its behavioural model. This covers the exact number and order of line and form feeds, where a wrapped search lands, the remapping of an out-of-range channel, the column-dependent extra line feed, the miss and zero-length invalidation, and loads being ignored while a stalled request is in progress.

// File: rtl/vfu_motion_pkg.sv
`timescale 1ns/1ps
package vfu_motion_pkg;

    localparam int unsigned ARG_W         = 4;
    localparam int unsigned TOF_BIT       = 0;
    localparam int unsigned TOP_CHANNEL   = 11;
    localparam int unsigned FALLBACK_CHAN = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLEW,
        ST_SRCH,
        ST_HITLF,
        ST_TOFLF,
        ST_FF,
        ST_TOFCHK,
        ST_DONE
    } vfu_state_e;

    typedef enum logic {
        REQ_SLEW = 1'b0,
        REQ_SEEK = 1'b1
    } req_kind_e;

    typedef struct packed {
        req_kind_e         kind;
        logic [ARG_W-1:0]  arg;
    } vfu_req_t;

    function automatic logic [ARG_W-1:0] map_channel(input logic [ARG_W-1:0] c);
        return (c > ARG_W'(TOP_CHANNEL)) ? ARG_W'(FALLBACK_CHAN) : c;
    endfunction

endpackage

// File: rtl/vfu_fmt.sv
`timescale 1ns/1ps
module vfu_fmt #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             kill,
    input  logic             adv,
    output logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] ptr,
    output logic [LEN_W-1:0] nxt
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] ptr_q;
    logic [LEN_W:0]   inc;

    // next entry with wrap at the loaded length
    assign inc = {1'b0, ptr_q} + {{LEN_W{1'b0}}, 1'b1};
    assign nxt = (inc >= {1'b0, len_q}) ? '0 : inc[LEN_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            ptr_q <= '0;
        end else if (load) begin
            len_q <= load_val;
            ptr_q <= '0;
        end else begin
            if (kill) len_q <= '0;
            if (adv)  ptr_q <= nxt;
        end
    end

    assign len = len_q;
    assign ptr = ptr_q;
endmodule

// File: rtl/vfu_page.sv
`timescale 1ns/1ps
module vfu_page #(
    parameter int unsigned PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_val,
    input  logic              dec,
    output logic [PAGE_W-1:0] cnt,
    output logic              zero,
    output logic              last
);
    logic [PAGE_W-1:0] cnt_q;
    logic              zero_q;

    // a decrement from one lands on zero
    assign last = (cnt_q == PAGE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            zero_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q  <= cnt_q - PAGE_W'(1);
            zero_q <= last;
        end
    end

    assign cnt  = cnt_q;
    assign zero = zero_q;
endmodule

// File: rtl/vfu_ctrl.sv
`timescale 1ns/1ps
module vfu_ctrl
    import vfu_motion_pkg::*;
#(
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned ENTRY_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  vfu_req_t           req,
    input  logic               hold,
    input  logic [LEN_W-1:0]   len,
    input  logic               col_nz,
    input  logic [ENTRY_W-1:0] entry,
    input  logic               feed_ready,
    input  logic               page_last,
    output logic               idle,
    output logic               req_ready,
    output logic               feed_valid,
    output logic               feed_ff,
    output logic               col_clr,
    output logic               done,
    output logic               halt,
    output logic               ptr_adv,
    output logic               fmt_kill,
    output logic               page_dec,
    output logic               use_nxt
);
    vfu_state_e       st_q;
    logic [LEN_W-1:0] cnt_q;
    logic [ARG_W-1:0] ch_q;
    logic             halt_q;
    logic             fire;
    logic             hit;
    logic             accept;
    logic [LEN_W-1:0] step_n;

    assign idle      = (st_q == ST_IDLE);
    assign req_ready = idle && !hold;
    assign accept    = req_ready && req_valid;

    assign feed_valid = (st_q == ST_SLEW) || (st_q == ST_HITLF) ||
                        (st_q == ST_TOFLF) || (st_q == ST_FF);
    assign feed_ff    = (st_q == ST_FF);
    assign fire       = feed_valid && feed_ready;
    assign col_clr    = fire && !feed_ff;

    assign hit    = entry[ch_q];
    assign step_n = cnt_q + LEN_W'(1);

    assign use_nxt  = (st_q == ST_SRCH);
    assign ptr_adv  = ((st_q == ST_SLEW) && fire) || (st_q == ST_SRCH);
    assign page_dec = ((st_q == ST_FF) && fire) ||
                      ((st_q == ST_TOFCHK) && entry[TOF_BIT]);
    assign fmt_kill = (accept && req.kind == REQ_SEEK && len == '0) ||
                      ((st_q == ST_SRCH) && !hit && step_n == len);

    assign done = (st_q == ST_DONE);
    assign halt = halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            ch_q   <= '0;
            halt_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        halt_q <= 1'b0;
                        if (req.kind == REQ_SLEW) begin
                            cnt_q <= LEN_W'(req.arg);
                            st_q  <= (req.arg == '0) ? ST_DONE : ST_SLEW;
                        end else begin
                            cnt_q <= '0;
                            ch_q  <= map_channel(req.arg);
                            if (len == '0) begin
                                halt_q <= 1'b1;
                                st_q   <= ST_DONE;
                            end else begin
                                st_q <= ST_SRCH;
                            end
                        end
                    end
                end
                ST_SLEW, ST_HITLF: begin
                    if (fire) begin
                        cnt_q <= cnt_q - LEN_W'(1);
                        if (cnt_q == LEN_W'(1)) st_q <= ST_TOFCHK;
                    end
                end
                ST_SRCH: begin
                    cnt_q <= step_n;
                    if (hit) begin
                        if (ch_q != '0)  st_q <= ST_HITLF;
                        else if (col_nz) st_q <= ST_TOFLF;
                        else             st_q <= ST_FF;
                    end else if (step_n == len) begin
                        halt_q <= 1'b1;
                        st_q   <= ST_DONE;
                    end
                end
                ST_TOFLF: begin
                    if (fire) st_q <= ST_FF;
                end
                ST_FF: begin
                    if (fire) begin
                        halt_q <= page_last;
                        st_q   <= ST_DONE;
                    end
                end
                ST_TOFCHK: begin
                    halt_q <= entry[TOF_BIT] && page_last;
                    st_q   <= ST_DONE;
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vfu_motion.sv
`timescale 1ns/1ps
module vfu_motion
    import vfu_motion_pkg::*;
#(
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned PAGE_W  = 12,
    parameter int unsigned ENTRY_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_kind,
    input  logic [ARG_W-1:0]   req_arg,
    input  logic               fmt_len_load,
    input  logic [LEN_W-1:0]   fmt_len_val,
    input  logic               page_load,
    input  logic [PAGE_W-1:0]  page_val,
    input  logic               col_nz,
    output logic [LEN_W-1:0]   mem_addr,
    input  logic [ENTRY_W-1:0] mem_data,
    output logic               feed_valid,
    input  logic               feed_ready,
    output logic               feed_ff,
    output logic               col_clr,
    output logic               done,
    output logic               halt,
    output logic               page_zero,
    output logic [PAGE_W-1:0]  page_cnt,
    output logic [LEN_W-1:0]   fmt_len,
    output logic [LEN_W-1:0]   fmt_ptr
);
    vfu_req_t         req;
    logic             idle;
    logic             hold;
    logic             ptr_adv;
    logic             fmt_kill;
    logic             page_dec;
    logic             page_last;
    logic             use_nxt;
    logic [LEN_W-1:0] nxt;

    assign req.kind = req_kind_e'(req_kind);
    assign req.arg  = req_arg;
    assign hold     = fmt_len_load || page_load;
    assign mem_addr = use_nxt ? nxt : fmt_ptr;

    vfu_fmt #(.LEN_W(LEN_W)) u_fmt (
        .clk      (clk),
        .rst      (rst),
        .load     (fmt_len_load && idle),
        .load_val (fmt_len_val),
        .kill     (fmt_kill),
        .adv      (ptr_adv),
        .len      (fmt_len),
        .ptr      (fmt_ptr),
        .nxt      (nxt)
    );

    vfu_page #(.PAGE_W(PAGE_W)) u_page (
        .clk      (clk),
        .rst      (rst),
        .load     (page_load && idle),
        .load_val (page_val),
        .dec      (page_dec),
        .cnt      (page_cnt),
        .zero     (page_zero),
        .last     (page_last)
    );

    vfu_ctrl #(.LEN_W(LEN_W), .ENTRY_W(ENTRY_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req        (req),
        .hold       (hold),
        .len        (fmt_len),
        .col_nz     (col_nz),
        .entry      (mem_data),
        .feed_ready (feed_ready),
        .page_last  (page_last),
        .idle       (idle),
        .req_ready  (req_ready),
        .feed_valid (feed_valid),
        .feed_ff    (feed_ff),
        .col_clr    (col_clr),
        .done       (done),
        .halt       (halt),
        .ptr_adv    (ptr_adv),
        .fmt_kill   (fmt_kill),
        .page_dec   (page_dec),
        .use_nxt    (use_nxt)
    );
endmodule

// File: rtl/vfu_motion_chk.sv
`timescale 1ns/1ps
module vfu_motion_chk #(
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned PAGE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              page_load,
    input logic              feed_valid,
    input logic              feed_ready,
    input logic              feed_ff,
    input logic              done,
    input logic              halt,
    input logic              page_zero,
    input logic [PAGE_W-1:0] page_cnt,
    input logic [LEN_W-1:0]  fmt_len,
    input logic [LEN_W-1:0]  fmt_ptr
);
    p_feed_hold_r8: assert property (@(posedge clk) disable iff (rst)
        feed_valid && !feed_ready |=> feed_valid && $stable(feed_ff));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !feed_valid && !done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_ptr_range_r5: assert property (@(posedge clk) disable iff (rst)
        fmt_len != '0 |-> fmt_ptr < fmt_len);

    p_halt_cause_r7: assert property (@(posedge clk) disable iff (rst)
        done && halt && !page_zero |-> fmt_len == '0);

    p_page_step_r3: assert property (@(posedge clk) disable iff (rst)
        (page_cnt != $past(page_cnt)) && !$past(page_load)
        |-> page_cnt == PAGE_W'($past(page_cnt) - PAGE_W'(1)));

    p_zero_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(page_zero) |-> page_cnt == '0);

    p_ff_page_r6: assert property (@(posedge clk) disable iff (rst)
        feed_valid && feed_ready && feed_ff
        |=> page_cnt == PAGE_W'($past(page_cnt) - PAGE_W'(1)));
endmodule

bind vfu_motion vfu_motion_chk #(.LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .page_load  (page_load),
    .feed_valid (feed_valid),
    .feed_ready (feed_ready),
    .feed_ff    (feed_ff),
    .done       (done),
    .halt       (halt),
    .page_zero  (page_zero),
    .page_cnt   (page_cnt),
    .fmt_len    (fmt_len),
    .fmt_ptr    (fmt_ptr)
);

// File: tb/vfu_motion_tb.sv
`timescale 1ns/1ps
module vfu_motion_tb;
    localparam int LEN_W = 8, PAGE_W = 12, ENTRY_W = 12;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_kind = 0;
    logic [3:0] req_arg = '0;
    logic fmt_len_load = 0, page_load = 0, col_nz = 0, feed_ready = 1;
    logic [LEN_W-1:0] fmt_len_val = '0;
    logic [PAGE_W-1:0] page_val = '0;
    logic [LEN_W-1:0] mem_addr, fmt_len, fmt_ptr;
    logic [ENTRY_W-1:0] mem_data;
    logic req_ready, feed_valid, feed_ff, col_clr, done, halt, page_zero;
    logic [PAGE_W-1:0] page_cnt;

    logic [ENTRY_W-1:0] mem [0:255];
    assign mem_data = mem[mem_addr];

    always #2.5 clk = ~clk;

    vfu_motion u_dut (.*);

    int n_chk = 0, n_fail = 0;
    int m_len = 0, m_ptr = 0, m_page = 0;
    bit m_pz = 0;
    bit exp_q[$];
    int rmode = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // printer side: ready pattern, changed just after each edge
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        feed_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 0) : 1'b0;
    end

    // per-clock comparison of every consumed feed against the model queue
    initial forever begin
        @(negedge clk);
        if (!rst && feed_valid && feed_ready) begin
            if (exp_q.size() == 0) check(0, "R8 unexpected feed", int'(feed_ff), -1);
            else begin
                bit e;
                e = exp_q.pop_front();
                check(feed_ff == e, "R1/R5/R6 feed kind", int'(feed_ff), int'(e));
                check(col_clr == !e, "R1 col_clr", int'(col_clr), int'(!e));
            end
        end
    end

    function automatic bit model_dec();
        m_page = (m_page - 1) & 12'hFFF;
        m_pz = (m_page == 0);
        return m_pz;
    endfunction

    task automatic set_len(input int v);
        fmt_len_load = 1; fmt_len_val = LEN_W'(v); tick(); fmt_len_load = 0;
        m_len = v; m_ptr = 0;
    endtask

    task automatic set_page(input int v);
        page_load = 1; page_val = PAGE_W'(v); tick(); page_load = 0;
        m_page = v;
    endtask

    task automatic run(input bit kind, input int arg, input bit cnz, input string tag);
        bit e_halt = 0;
        int guard;
        if (!kind) begin
            if (arg != 0) begin
                for (int i = 0; i < arg; i++) exp_q.push_back(1'b0);
                m_ptr = (m_len == 0) ? 0 : (m_ptr + arg) % m_len;
                if (mem[m_ptr][0]) e_halt = model_dec();
            end
        end else begin
            int ch, p, k;
            bit found = 0;
            ch = (arg > 11) ? 7 : arg;
            p = m_ptr; k = 0;
            for (int i = 1; i <= m_len && !found; i++) begin
                p = (p + 1) % m_len;
                if (mem[p][ch]) begin found = 1; k = i; end
            end
            if (!found) begin
                m_len = 0; e_halt = 1;
            end else begin
                m_ptr = p;
                if (ch != 0) begin
                    for (int i = 0; i < k; i++) exp_q.push_back(1'b0);
                    if (mem[p][0]) e_halt = model_dec();
                end else begin
                    if (cnz) exp_q.push_back(1'b0);
                    exp_q.push_back(1'b1);
                    e_halt = model_dec();
                end
            end
        end
        col_nz = cnz; req_kind = kind; req_arg = 4'(arg); req_valid = 1;
        do @(negedge clk); while (!req_ready);
        tick(); req_valid = 0;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!done && guard < 500);
        check(done, {tag, " done seen"}, int'(done), 1);
        check(halt == e_halt, {tag, " halt"}, int'(halt), int'(e_halt));
        check(exp_q.size() == 0, {tag, " feeds left"}, exp_q.size(), 0);
        check(page_cnt == PAGE_W'(m_page), {tag, " page"}, int'(page_cnt), m_page);
        check(page_zero == m_pz, {tag, " page_zero"}, int'(page_zero), int'(m_pz));
        check(fmt_len == LEN_W'(m_len), {tag, " len"}, int'(fmt_len), m_len);
        check(fmt_ptr == LEN_W'(m_ptr), {tag, " ptr"}, int'(fmt_ptr), m_ptr);
        exp_q.delete();
        tick();
        check(!done, {tag, " R9 done one cycle"}, int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[0] = 12'h009;   // top of form + channel 3
        mem[3] = 12'h004;   // channel 2
        mem[4] = 12'h800;   // channel 11
        mem[5] = 12'h080;   // channel 7
        repeat (4) tick();
        rst = 0;
        @(negedge clk);
        check(req_ready, "R11 ready", int'(req_ready), 1);
        check(!feed_valid && !done, "R11 no feed", int'(feed_valid), 0);
        check(page_cnt == 0 && !page_zero, "R11 page", int'(page_cnt), 0);
        check(fmt_len == 0 && fmt_ptr == 0, "R11 fmt", int'(fmt_len), 0);
        tick();

        set_len(6);
        set_page(3);
        check(fmt_len == 6 && fmt_ptr == 0, "R10 idle len load", int'(fmt_len), 6);
        run(0, 0, 0, "R2 zero slew");
        run(0, 2, 0, "R1 slew 2");
        run(0, 4, 0, "R1 R3 slew wrap tof");
        run(1, 2, 0, "R5 seek ch2");
        run(1, 13, 0, "R4 ch13 to ch7");
        run(1, 0, 1, "R6 ch0 col nonzero");
        rmode = 1;
        run(1, 3, 0, "R3 R8 seek ch3 wrap page zero");
        rmode = 0;
        set_page(2);
        run(1, 11, 0, "R5 seek ch11");
        rmode = 2;
        fork
            run(0, 3, 0, "R10 busy loads ignored");
            begin
                repeat (5) tick();
                fmt_len_load = 1; fmt_len_val = 8'd200; page_load = 1; page_val = 12'd77;
                tick();
                fmt_len_load = 0; page_load = 0;
                check(fmt_len == 6 && page_cnt == 2, "R10 busy load", int'(fmt_len), 6);
                rmode = 0;
            end
        join
        run(1, 0, 0, "R6 ch0 col zero");
        run(1, 9, 0, "R7 miss");
        run(1, 5, 0, "R7 zero length");
        run(0, 2, 0, "R1 R3 slew at zero length");
        set_page(0);
        set_len(6);
        run(0, 6, 0, "R3 page wrap");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule